// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

A clocked single-port memory with one shared bidirectional data bus, built to sit between a processor and a cache controller with no glue logic. Each word is 18 bits: sixteen data bits and two parity bits. The parity bits are stored and returned exactly like data. The depth is `2**ADDR_W` words. The full-size part uses `ADDR_W = 16`, which gives 64K words. The default is smaller so that the model elaborates quickly.

An access begins when either the processor strobe or the controller strobe is seen at a rising clock edge. At that edge the address register captures the full address. A 2-bit counter then supplies the low address bits for the other three words of the 4-word group, and it steps only on edges where the advance input is high. A build parameter sets the wrap order. The interleaved order is the start bits XOR the count. The linear order is the start bits plus the count, modulo 4.

Writes are synchronous and self-timed. Each 9-bit half of the word has its own write enable. Chip select is sampled only at a strobe. Output enable acts on the bus drivers without waiting for a clock edge.

Top module: `sync_burst_sram`

## Requirements
- R1: Every stored word holds all 18 bits. Bits 17:16 (parity) are written and read back exactly like bits 15:0.
- R2: A strobe (`cpu_ads` or `ctl_ads`) with `cs` high at a rising edge captures `addr` and sets the burst count to 0. From that edge, the bus carries the word at the captured address.
- R3: With `INTERLEAVED = 1`, the k-th word of a burst (k = 0..3, wrapping) has low address bits = start[1:0] XOR k. Bits above bit 1 stay fixed.
- R4: With `INTERLEAVED = 0`, the k-th word has low address bits = (start[1:0] + k) mod 4. Bits above bit 1 stay fixed.
- R5: During a burst, an edge with `adv` low and no strobe leaves the address and the bus data unchanged, and performs no write.
- R6: On a `ctl_ads` cycle, and on the advance cycles after it, `we_hi` writes bits 17:9 and `we_lo` writes bits 8:0 of the current word. The other half is left unchanged.
- R7: A cycle started by `cpu_ads`, and the advance cycles after it, are reads. The write enables have no effect on them.
- R8: When both strobes are high on the same edge, `cpu_ads` wins and the cycle is a read.
- R9: A strobe in the middle of a burst reloads the address and restarts the count from 0.
- R10: A strobe with `cs` low is ignored and writes nothing. From that edge the bus is high impedance.
- R11: `oe` low puts the bus in high impedance at once, without a clock edge. Raising it again restores the held read data.
- R12: The block never drives the bus while a write enable is high, or between reset and the first selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address, captured on a strobe |
| cpu_ads | input | 1 | Processor address strobe (read start; wins over ctl_ads) |
| ctl_ads | input | 1 | Cache-controller address strobe (read or write start) |
| adv | input | 1 | Step to the next word of the burst |
| cs | input | 1 | Chip select, sampled at a strobe |
| we_hi | input | 1 | Write enable for bits 17:9 |
| we_lo | input | 1 | Write enable for bits 8:0 |
| oe | input | 1 | Asynchronous output enable |
| dq | inout | 18 | Shared data bus: data 15:0, parity 17:16 |

## Verification
The bench writes a burst that starts at an odd word and reads it back through two builds, one per order. Start offsets 0 and 3 are chosen so that a mix-up between XOR and addition puts a different word on the bus. A wrong order rule, or a counter that does not wrap, shows up as a value that belongs to another word of the group.

It then targets a strobe in mid-burst, a deselected strobe, both strobes together, and write enables on processor cycles and on hold cycles. A design that gets one of these wrong either keeps the old count or overwrites a word that must survive, and a later read-back exposes it.

High impedance is checked by weakly probing the bus with zeros. A block that drives while deselected, during a write, or with output enable low spoils the probe.

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram #(
  parameter int ADDR_W      = 10,
  parameter int INTERLEAVED = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cpu_ads,
  input  logic              ctl_ads,
  input  logic              adv,
  input  logic              cs,
  input  logic              we_hi,
  input  logic              we_lo,
  input  logic              oe,
  inout  wire  [17:0]       dq
);
  localparam int DW    = 18;
  localparam int HW    = DW / 2;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]     mem [DEPTH];
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic              active, wr_ok, drive_q;
  logic [DW-1:0]     rd_q;

  wire start  = cpu_ads | ctl_ads;
  wire load   = start & cs;
  wire step   = ~start & adv & active;
  wire access = load | step;

  wire [1:0] nxt_cnt = load ? 2'd0 : cnt + 2'd1;
  wire [1:0] seed    = load ? addr[1:0] : base[1:0];
  wire [ADDR_W-3:0] upper = load ? addr[ADDR_W-1:2] : base[ADDR_W-1:2];
  wire [1:0] lo_bits = (INTERLEAVED != 0) ? (seed ^ nxt_cnt) : (seed + nxt_cnt);
  wire [ADDR_W-1:0] eff = {upper, lo_bits};

  wire wr_allow = load ? ~cpu_ads : wr_ok;
  wire wr_hi    = access & wr_allow & we_hi;
  wire wr_lo    = access & wr_allow & we_lo;
  wire writing  = wr_hi | wr_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base    <= '0;
      cnt     <= 2'd0;
      active  <= 1'b0;
      wr_ok   <= 1'b0;
      drive_q <= 1'b0;
    end else if (start) begin
      if (cs) begin
        base    <= addr;
        cnt     <= 2'd0;
        active  <= 1'b1;
        wr_ok   <= ~cpu_ads;
        drive_q <= ~writing;
      end else begin
        active  <= 1'b0;
        wr_ok   <= 1'b0;
        drive_q <= 1'b0;
      end
    end else if (step) begin
      cnt     <= cnt + 2'd1;
      drive_q <= ~writing;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hi) mem[eff][DW-1:HW] <= dq[DW-1:HW];
    if (wr_lo) mem[eff][HW-1:0]  <= dq[HW-1:0];
    if (access) rd_q <= mem[eff];
  end

  assign dq = (drive_q & oe & ~we_hi & ~we_lo) ? rd_q : {DW{1'bz}};

  p_load_clears_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cs) |=> (cnt == 2'd0 && active));

  p_hold_keeps_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !adv && !start) |=> ($stable(cnt) && $stable(base) && $stable(rd_q)));

  p_advance_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && adv && !start) |=> (cnt == $past(cnt) + 2'd1));

  p_cpu_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ads && cs) |=> !wr_ok);

  p_deselect_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cs) |=> (!drive_q && !active));

  p_restart_midburst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start && cs) |=> (base == $past(addr)));
endmodule

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cpu_ads, ctl_ads, adv, cs, we_hi, we_lo, oe;
  logic [9:0] addr;
  logic drv_en;
  logic [17:0] drv_val;
  wire  [17:0] dq_a, dq_b;
  assign dq_a = drv_en ? drv_val : 18'bz;
  assign dq_b = drv_en ? drv_val : 18'bz;

  sync_burst_sram #(.ADDR_W(10), .INTERLEAVED(1)) i_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_ads(cpu_ads), .ctl_ads(ctl_ads),
    .adv(adv), .cs(cs), .we_hi(we_hi), .we_lo(we_lo), .oe(oe), .dq(dq_a));

  sync_burst_sram #(.ADDR_W(10), .INTERLEAVED(0)) i_sync_burst_sram_lin (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_ads(cpu_ads), .ctl_ads(ctl_ads),
    .adv(adv), .cs(cs), .we_hi(we_hi), .we_lo(we_lo), .oe(oe), .dq(dq_b));

  int checks = 0;
  int errors = 0;

  localparam logic [17:0] D0 = 18'h30011;
  localparam logic [17:0] D1 = 18'h00122;
  localparam logic [17:0] D2 = 18'h2F0F3;
  localparam logic [17:0] D3 = 18'h1C3C4;

  typedef struct packed {
    logic cpu; logic ctl; logic adv; logic cs;
    logic [1:0] we; logic [9:0] a; logic [17:0] d;
    logic chk; logic [17:0] ea; logic [17:0] eb;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,2'b11,10'h041,D0,   1'b0,18'h0,18'h0},
    '{1'b0,1'b0,1'b1,1'b1,2'b11,10'h000,D1,   1'b0,18'h0,18'h0},
    '{1'b0,1'b0,1'b1,1'b1,2'b11,10'h000,D2,   1'b0,18'h0,18'h0},
    '{1'b0,1'b0,1'b1,1'b1,2'b11,10'h000,D3,   1'b0,18'h0,18'h0},
    '{1'b1,1'b0,1'b0,1'b1,2'b00,10'h040,18'h0,1'b1,D1,D3},
    '{1'b0,1'b0,1'b1,1'b1,2'b00,10'h000,18'h0,1'b1,D0,D0},
    '{1'b0,1'b0,1'b1,1'b1,2'b00,10'h000,18'h0,1'b1,D3,D1},
    '{1'b0,1'b0,1'b1,1'b1,2'b00,10'h000,18'h0,1'b1,D2,D2},
    '{1'b0,1'b0,1'b0,1'b1,2'b00,10'h000,18'h0,1'b1,D2,D2},
    '{1'b0,1'b0,1'b1,1'b1,2'b00,10'h000,18'h0,1'b1,D1,D3},
    '{1'b1,1'b0,1'b0,1'b1,2'b00,10'h043,18'h0,1'b1,D2,D2},
    '{1'b0,1'b0,1'b1,1'b1,2'b00,10'h000,18'h0,1'b1,D3,D3},
    '{1'b0,1'b0,1'b1,1'b1,2'b00,10'h000,18'h0,1'b1,D0,D0}
  };

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_ads = 0; ctl_ads = 0; adv = 0; we_hi = 0; we_lo = 0; drv_en = 0; cs = 1;
  endtask

  task automatic cyc(input logic c_cpu, input logic c_ctl, input logic c_adv, input logic c_cs,
                     input logic [1:0] c_we, input logic [9:0] c_a, input logic [17:0] c_d);
    cpu_ads = c_cpu; ctl_ads = c_ctl; adv = c_adv; cs = c_cs;
    we_hi = c_we[1]; we_lo = c_we[0]; addr = c_a;
    drv_en = |c_we; drv_val = c_d;
    @(posedge clk);
    @(negedge clk);
    idle();
    #0.5;
  endtask

  task automatic both(input string tag, input logic [17:0] ea, input logic [17:0] eb);
    check({tag, " interleaved"}, dq_a, ea);
    check({tag, " linear"}, dq_b, eb);
  endtask

  task automatic floats(input string tag);
    drv_en = 1; drv_val = 18'h0;
    #0.5;
    check({tag, " bus released (interleaved)"}, dq_a, 18'h0);
    check({tag, " bus released (linear)"}, dq_b, 18'h0);
    drv_en = 0;
    #0.5;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle(); oe = 1; addr = '0; drv_val = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    floats("R12 during reset");
    rst_n = 1;
    @(negedge clk);
    floats("R12 after reset");

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].cpu, VEC[i].ctl, VEC[i].adv, VEC[i].cs, VEC[i].we, VEC[i].a, VEC[i].d);
      if (VEC[i].chk) both($sformatf("R1/R2/R3/R4/R5 row %0d", i), VEC[i].ea, VEC[i].eb);
    end

    // R7: write enables on a processor-strobe cycle and its advance
    cyc(1, 0, 0, 1, 2'b11, 10'h043, 18'h15555);
    cyc(0, 0, 1, 1, 2'b11, 10'h000, 18'h15555);
    cyc(1, 0, 0, 1, 2'b00, 10'h043, 18'h0);
    both("R7 cpu cycle not written", D2, D2);
    cyc(0, 0, 1, 1, 2'b00, 10'h000, 18'h0);
    both("R7 cpu advance not written", D3, D3);

    // R8: both strobes together
    cyc(1, 1, 0, 1, 2'b11, 10'h043, 18'h00000);
    cyc(1, 0, 0, 1, 2'b00, 10'h043, 18'h0);
    both("R8 cpu strobe wins", D2, D2);

    // R6: half-word writes
    cyc(0, 1, 0, 1, 2'b11, 10'h100, 18'h3FFFF);
    cyc(0, 1, 0, 1, 2'b10, 10'h100, 18'h00000);
    cyc(1, 0, 0, 1, 2'b00, 10'h100, 18'h0);
    both("R6 high half only", 18'h001FF, 18'h001FF);
    cyc(0, 1, 0, 1, 2'b01, 10'h100, 18'h3FF55);
    cyc(1, 0, 0, 1, 2'b00, 10'h100, 18'h0);
    both("R6 low half only", 18'h00155, 18'h00155);

    // R9: restart in mid-burst
    cyc(1, 0, 0, 1, 2'b00, 10'h040, 18'h0);
    both("R9 first word", D1, D3);
    cyc(0, 0, 1, 1, 2'b00, 10'h000, 18'h0);
    both("R9 second word", D0, D0);
    cyc(0, 1, 0, 1, 2'b00, 10'h042, 18'h0);
    both("R9 reloaded address", D3, D1);
    cyc(0, 0, 1, 1, 2'b00, 10'h000, 18'h0);
    both("R9 count restarted", D2, D2);

    // R10: deselected strobes
    cyc(1, 0, 0, 0, 2'b00, 10'h040, 18'h0);
    floats("R10 deselected read");
    cyc(0, 1, 0, 0, 2'b11, 10'h040, 18'h00000);
    cyc(1, 0, 0, 1, 2'b00, 10'h040, 18'h0);
    both("R10 deselected write ignored", D1, D3);

    // R11: asynchronous output enable
    oe = 0;
    floats("R11 oe low");
    oe = 1;
    #0.5;
    both("R11 oe restored", D1, D3);

    // R12 and R5: write enable on a hold cycle of a controller burst
    cyc(0, 1, 0, 1, 2'b00, 10'h040, 18'h0);
    we_lo = 1;
    floats("R12 write enable releases bus");
    we_lo = 0;
    cyc(0, 0, 0, 1, 2'b01, 10'h000, 18'h00000);
    cyc(1, 0, 0, 1, 2'b00, 10'h040, 18'h0);
    both("R5 hold cycle wrote nothing", D1, D3);

    finish_run();
  end
endmodule